// File: doc/BRIEF.md
# Sound Unit Status and Control Register

This block is the single-address control and status register of a five-channel sound generator. A bus write sets the enables of the four channels that have length counters. For each of those channels it sends a clear pulse to any counter whose enable was written to 0, and it holds that counter at zero while the enable stays low. The same write also controls the sample-playback channel. It either stops the sample engine or asks it to restart, and the engine restarts only if it has no bytes left to play.

A bus read returns a snapshot built from the counter-nonzero inputs, the sample-bytes-remaining input and two interrupt flags. The block keeps those two flags itself. The frame flag is set by the frame sequencer and cleared by a read. The sample flag is set by the sample engine and cleared by a write. A set pulse always wins over a clear in the same cycle. A read also shows a set pulse that arrives in the same cycle. A combined interrupt request goes to the processor.

Top module: `snd_status_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, all enables, both flags, `irq`, every pulse output and `rdata` are 0. All four `len_hold` bits are 1.
- R2: A write (`sel` and `wr_en`) loads `wdata[3:0]` into `len_enable` on the next cycle. Bit 0 is pulse 1, bit 1 is pulse 2, bit 2 is triangle and bit 3 is noise. `len_hold` is the inverse of `len_enable` at all times.
- R3: On the cycle after a write, `len_clear` is high for exactly one cycle on each channel whose written enable bit was 0. It is low on every channel written to 1.
- R4: A write with `wdata[4]` at 0 gives a one-cycle `smp_stop` pulse on the next cycle, and no restart.
- R5: A write with `wdata[4]` at 1 gives a one-cycle `smp_restart` pulse on the next cycle only if `smp_active` was 0 during the write. If bytes remain, neither pulse occurs.
- R6: A write clears the sample flag, unless `smp_irq_set` is high in the same cycle. A write never clears the frame flag.
- R7: During a read, `rdata` is laid out as follows: bit 7 is the sample flag, bit 6 the frame flag, bit 5 is 0, bit 4 is `smp_active`, and bits 3:0 are `len_active`. A flag bit also reads 1 if its set pulse is high in that cycle. `rdata` is 0 when no read is strobed.
- R8: A read clears the frame flag and leaves the sample flag unchanged.
- R9: If `frame_irq_set` is high in the same cycle as a read, the read returns 1 in bit 6 and the frame flag stays set afterwards.
- R10: A set pulse raises its flag on the next cycle. `irq` is high exactly when at least one flag is set.
- R11: `wr_en` or `rd_en` without `sel` has no effect on enables, pulses, flags or `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Address match for this register |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read strobe |
| len_active | input | 4 | Length counters nonzero, one bit per channel |
| smp_active | input | 1 | Sample bytes remaining nonzero |
| frame_irq_set | input | 1 | Frame interrupt set pulse |
| smp_irq_set | input | 1 | Sample interrupt set pulse |
| len_enable | output | 4 | Length counter enables |
| len_clear | output | 4 | One-cycle clear pulse per disabled counter |
| len_hold | output | 4 | Hold-at-zero level per disabled counter |
| smp_stop | output | 1 | Forces sample bytes remaining to zero |
| smp_restart | output | 1 | Restarts the sample from its start |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the uneven side effects on the two flags. A read that also cleared the sample flag would drop `irq` early. A write that cleared the frame flag would lose a pending frame interrupt. A design where the clear wins the race with a set pulse would return 0, or lose the flag, when a set pulse arrives during a read. The bench also writes the sample-channel bit with and without bytes remaining, because a design that restarts a sample that is still playing would disturb playback. Finally, it strobes both reads and writes without the address match, to catch decoding that ignores `sel`.

// File: rtl/snd_status_pkg.sv
package snd_status_pkg;
  localparam int NUM_LEN     = 4;
  localparam int DATA_W      = 8;
  localparam int SMP_CTL_BIT = 4;
  localparam int SMP_IRQ_BIT = 7;
  localparam int FRM_IRQ_BIT = 6;
  localparam int RSV_BIT     = 5;

  typedef struct packed {
    logic               smp_on;
    logic [NUM_LEN-1:0] len_en;
  } wr_fields_t;
endpackage

// File: rtl/snd_irq_flag.sv
module snd_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q,
  output logic view_o
);
  logic flag_d;

  always_comb begin
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign view_o = flag_q | set_i;
endmodule

// File: rtl/snd_len_ctrl.sv
module snd_len_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [N-1:0] en_bits,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] clear_q,
  output logic [N-1:0] hold_o
);
  logic [N-1:0] clear_d;

  for (genvar g = 0; g < N; g++) begin : g_chan
    always_comb clear_d[g] = wr_stb & ~en_bits[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enable_q[g] <= 1'b0;
      end else if (wr_stb) begin
        enable_q[g] <= en_bits[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clear_q[g] <= 1'b0;
      else        clear_q[g] <= clear_d[g];
    end

    assign hold_o[g] = ~enable_q[g];
  end
endmodule

// File: rtl/snd_smp_ctrl.sv
module snd_smp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic smp_bit,
  input  logic smp_active,
  output logic stop_q,
  output logic restart_q
);
  logic stop_d, restart_d;

  always_comb begin
    stop_d    = wr_stb & ~smp_bit;
    restart_d = wr_stb & smp_bit & ~smp_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      stop_q    <= stop_d;
      restart_q <= restart_d;
    end
  end
endmodule

// File: rtl/snd_rd_mux.sv
module snd_rd_mux
  import snd_status_pkg::*;
(
  input  logic               rd_stb,
  input  logic               smp_irq,
  input  logic               frm_irq,
  input  logic               smp_active,
  input  logic [NUM_LEN-1:0] len_active,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      rdata[SMP_IRQ_BIT]   = smp_irq;
      rdata[FRM_IRQ_BIT]   = frm_irq;
      rdata[RSV_BIT]       = 1'b0;
      rdata[SMP_CTL_BIT]   = smp_active;
      rdata[NUM_LEN-1:0]   = len_active;
    end
  end
endmodule

// File: rtl/snd_status_reg.sv
module snd_status_reg
  import snd_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_LEN-1:0] len_active,
  input  logic               smp_active,
  input  logic               frame_irq_set,
  input  logic               smp_irq_set,
  output logic [NUM_LEN-1:0] len_enable,
  output logic [NUM_LEN-1:0] len_clear,
  output logic [NUM_LEN-1:0] len_hold,
  output logic               smp_stop,
  output logic               smp_restart,
  output logic               irq
);
  logic       wr_stb, rd_stb;
  logic       frm_flag_q, smp_flag_q;
  logic       frm_view, smp_view;
  wr_fields_t wf;
  logic       unused_wbits;

  assign wr_stb       = sel & wr_en;
  assign rd_stb       = sel & rd_en;
  assign wf           = wdata[SMP_CTL_BIT:0];
  assign unused_wbits = ^wdata[DATA_W-1:SMP_CTL_BIT+1];

  snd_len_ctrl #(.N(NUM_LEN)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .en_bits (wf.len_en),
    .enable_q(len_enable),
    .clear_q (len_clear),
    .hold_o  (len_hold)
  );

  snd_smp_ctrl u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .smp_bit   (wf.smp_on),
    .smp_active(smp_active),
    .stop_q    (smp_stop),
    .restart_q (smp_restart)
  );

  snd_irq_flag u_frm_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (frame_irq_set),
    .clr_i (rd_stb),
    .flag_q(frm_flag_q),
    .view_o(frm_view)
  );

  snd_irq_flag u_smp_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (smp_irq_set),
    .clr_i (wr_stb),
    .flag_q(smp_flag_q),
    .view_o(smp_view)
  );

  snd_rd_mux u_rd (
    .rd_stb    (rd_stb),
    .smp_irq   (smp_view),
    .frm_irq   (frm_view),
    .smp_active(smp_active),
    .len_active(len_active),
    .rdata     (rdata)
  );

  assign irq = frm_flag_q | smp_flag_q;
endmodule

// File: rtl/snd_status_chk.sv
module snd_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       smp_active,
  input logic       frame_irq_set,
  input logic       smp_irq_set,
  input logic [3:0] len_enable,
  input logic [3:0] len_clear,
  input logic       smp_stop,
  input logic       smp_restart,
  input logic       irq,
  input logic       frame_q,
  input logic       smp_q
);
  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en) |=> (len_enable == $past(wdata[3:0])));

  p_clear_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en) |=> (len_clear == ~$past(wdata[3:0])));

  p_no_pulse_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en) |=> (len_clear == 4'b0 && !smp_stop && !smp_restart));

  p_restart_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && wdata[4] && smp_active) |=> (!smp_restart && !smp_stop));

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !wdata[4]) |=> smp_stop);

  p_wr_clears_smp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !smp_irq_set) |=> !smp_q);

  p_wr_keeps_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !(sel && rd_en) && frame_q) |=> frame_q);

  p_rd_clears_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_en && !frame_irq_set) |=> !frame_q);

  p_rd_keeps_smp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_en && !(sel && wr_en) && smp_q) |=> smp_q);

  p_race_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq_set |=> (frame_q && irq));

  p_smp_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_irq_set |=> irq);

  always_comb begin
    if (rst_n) begin
      a_rsv_zero_r7: assert (rdata[5] == 1'b0);
      a_one_action_r5: assert (!(smp_stop && smp_restart));
    end
  end
endmodule

bind snd_status_reg snd_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel          (sel),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .smp_active   (smp_active),
  .frame_irq_set(frame_irq_set),
  .smp_irq_set  (smp_irq_set),
  .len_enable   (len_enable),
  .len_clear    (len_clear),
  .smp_stop     (smp_stop),
  .smp_restart  (smp_restart),
  .irq          (irq),
  .frame_q      (frm_flag_q),
  .smp_q        (smp_flag_q)
);

// File: tb/tb_snd_status_reg.sv
`timescale 1ns/1ps
module tb_snd_status_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic [3:0] len_active, len_enable, len_clear, len_hold;
  logic       smp_active, frame_irq_set, smp_irq_set;
  logic       smp_stop, smp_restart, irq;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  snd_status_reg dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .len_active(len_active),
    .smp_active(smp_active), .frame_irq_set(frame_irq_set),
    .smp_irq_set(smp_irq_set), .len_enable(len_enable),
    .len_clear(len_clear), .len_hold(len_hold), .smp_stop(smp_stop),
    .smp_restart(smp_restart), .irq(irq)
  );

  // {wdata[4:0], smp_active, exp_enable[3:0], exp_clear[3:0], exp_stop, exp_restart}
  localparam logic [15:0] VEC [6] = '{
    16'b11111_0_1111_0000_0_1,
    16'b11111_1_1111_0000_0_0,
    16'b00101_1_0101_1010_1_0,
    16'b00000_0_0000_1111_1_0,
    16'b11010_0_1010_0101_0_1,
    16'b10001_1_0001_1110_0_0
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic idle();
    sel = 0; wr_en = 0; rd_en = 0; wdata = 8'h00;
    frame_irq_set = 0; smp_irq_set = 0;
  endtask

  // write during one cycle; returns at the negedge after the capturing edge
  task automatic do_write(input logic [7:0] d, input logic s);
    @(negedge clk);
    sel = s; wr_en = 1; wdata = d;
    @(negedge clk);
    idle();
  endtask

  // read: sample rdata in the strobe cycle, return at the following negedge
  task automatic do_read(input logic s, output logic [7:0] v);
    @(negedge clk);
    sel = s; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_irq_set = 1;
    @(negedge clk); frame_irq_set = 0;
  endtask

  task automatic pulse_smp();
    @(negedge clk); smp_irq_set = 1;
    @(negedge clk); smp_irq_set = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle();
    len_active = 4'h0; smp_active = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 enables in reset", {4'h0, len_enable}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hold after reset", {4'h0, len_hold}, 8'h0F);
    chk("R1 pulses/irq after reset", {4'h0, len_clear}, 8'h00);
    chk("R1 stop/restart/irq", {5'b0, smp_stop, smp_restart, irq}, 8'h00);
    chk("R1 rdata idle", rdata, 8'h00);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      smp_active = VEC[i][10];
      do_write({3'b000, VEC[i][15:11]}, 1'b1);
      chk("R2 enable", {4'h0, len_enable}, {4'h0, VEC[i][9:6]});
      chk("R2 hold", {4'h0, len_hold}, {4'h0, ~VEC[i][9:6]});
      chk("R3 clear pulse", {4'h0, len_clear}, {4'h0, VEC[i][5:2]});
      chk("R4 stop", {7'b0, smp_stop}, {7'b0, VEC[i][1]});
      chk("R5 restart", {7'b0, smp_restart}, {7'b0, VEC[i][0]});
      @(negedge clk);
      chk("R3 pulse one cycle", {2'b0, smp_stop, smp_restart, len_clear}, 8'h00);
    end
    smp_active = 0;

    // R7 read layout
    len_active = 4'b1010; smp_active = 1;
    do_read(1'b1, v);
    chk("R7 layout", v, 8'h1A);
    len_active = 4'h0; smp_active = 0;

    // R10 R8 frame flag
    pulse_frame();
    chk("R10 irq from frame", {7'b0, irq}, 8'h01);
    do_read(1'b1, v);
    chk("R7 frame bit", v, 8'h40);
    chk("R8 read clears frame", {7'b0, irq}, 8'h00);

    // R8 R6 sample flag
    pulse_smp();
    do_read(1'b1, v);
    chk("R7 sample bit", v, 8'h80);
    chk("R8 read keeps sample", {7'b0, irq}, 8'h01);
    do_write(8'h00, 1'b1);
    chk("R6 write clears sample", {7'b0, irq}, 8'h00);

    // R6 write keeps frame
    pulse_frame();
    do_write(8'h1F, 1'b1);
    do_read(1'b1, v);
    chk("R6 write keeps frame", v, 8'h40);

    // R9 race
    @(negedge clk);
    sel = 1; rd_en = 1; frame_irq_set = 1;
    #1 v = rdata;
    @(negedge clk);
    idle();
    chk("R9 race reads one", v, 8'h40);
    chk("R9 flag stays", {7'b0, irq}, 8'h01);
    do_read(1'b1, v);
    chk("R9 still set", v, 8'h40);
    do_read(1'b1, v);
    chk("R8 cleared after read", v, 8'h00);

    // R11 strobes without sel
    do_write(8'h00, 1'b0);
    chk("R11 enables unchanged", {4'h0, len_enable}, 8'h0F);
    chk("R11 no pulses", {2'b0, smp_stop, smp_restart, len_clear}, 8'h00);
    pulse_frame();
    do_read(1'b0, v);
    chk("R11 rdata without sel", v, 8'h00);
    do_read(1'b1, v);
    chk("R11 flag kept", v, 8'h40);

    // R6 set during write wins
    @(negedge clk);
    sel = 1; wr_en = 1; wdata = 8'h1F; smp_irq_set = 1;
    @(negedge clk);
    idle();
    chk("R6 set beats write", {7'b0, irq}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule